// File: doc/BRIEF.md
# Break and Sync Baud-Rate Detector

This block recovers the bit rate of a serial line from a synchronisation preamble. The preamble is a long low break, then a high delimiter, then the character 0x55 sent least significant bit first. With detection enabled, the receive side qualifies the break against a bit-time reference and checks the delimiter against a programmable minimum. It then times the sync character with a 16-bit counter and publishes a new divisor, in clock cycles per bit, with a one-cycle done pulse. A break that runs too long raises one sticky error flag. A sync character too slow for the counter raises a second flag and leaves the divisor as it was.

The same block holds a transmit sequencer that produces the preamble. When a break request is present and the byte 0x55 is written while detection is enabled, it sends a break, a delimiter and the sync frame. When detection is disabled, writing 0x00 with the break request sends a lone break. The bit-time reference sets the length of every transmitted bit, so the transmitter looped back into the receiver reproduces that reference as the measured divisor.

Top module: `brk_sync_autobaud`

## Requirements
- R1: After reset the divisor is 0, the done pulse and both error flags are low, the transmit output is high and the sequencer is not busy.
- R2: A break is accepted only if the input is sampled low on at least 11×bitTime consecutive clocks before it goes high. A shorter low pulse starts no measurement.
- R3: The delimiter that follows an accepted break must be sampled high on at least (delimSel+1)×bitTime clocks, with delimSel 0..3 meaning 1..4 bit times. A shorter delimiter is treated as the start of a new break candidate.
- R4: The measurement runs from the first falling edge after the delimiter to the fifth falling edge, which is the start of data bit 7 of 0x55. At that edge the divisor becomes the clock count between the two edges shifted right by 3. The done pulse is high for exactly that one cycle.
- R5: If the break is sampled low on more than 22×bitTime clocks, the break-timeout flag is set and no measurement follows. Exactly 22×bitTime is a valid break. Both flags clear at the start of the next break candidate.
- R6: If the 16-bit measurement count reaches 65535 before the fifth falling edge, the sync-timeout flag is set and the divisor keeps its previous value.
- R7: While enable is low, no detection takes place and both error flags are held clear.
- R8: A write of 0x55 with the break request high, while enabled and idle, drives 13 bit times low, then (delimSel+1) bit times high, then the frame start 0, bits of 0x55 LSB first, stop 1. Every bit lasts bitTime clocks and busy is high throughout.
- R9: A write of 0x00 with the break request high, while disabled and idle, drives 13 bit times low, then returns high and not busy.
- R10: Any other transmit write is ignored: a wrong byte for the current mode, a write without the break request, or a write while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Detection enable and transmit mode select |
| rxIn | input | 1 | Serial input, idle high |
| bitTime | input | 16 | Current bit time in clock cycles |
| delimSel | input | 2 | Delimiter length code, value+1 bit times |
| txBreakReq | input | 1 | Break request for the next transmit write |
| txWrite | input | 1 | Transmit byte write strobe |
| txByte | input | 8 | Byte written with the strobe |
| divisor | output | 16 | Measured clock cycles per bit |
| detectDone | output | 1 | One-cycle pulse on a completed measurement |
| breakTimeout | output | 1 | Sticky break-too-long flag |
| syncTimeout | output | 1 | Sticky measurement-overflow flag |
| txOut | output | 1 | Serial output, idle high |
| txBusy | output | 1 | Transmit sequence in progress |

## Verification
The hardest case to reach is measurement overflow. Only a sync character of about 8200 clocks per bit fills the 16-bit counter, and the stimulus must keep that slow waveform from being taken as a new break after the overflow. The bench drives a normal break and delimiter at a small bitTime. It sends only the first eight segments of a slow 0x55, so the line is high when the counter fills, and then holds the line idle to read the flag. The delimiter and break limits are each driven exactly at and one clock past their thresholds. The transmitter is looped back so that its waveform and the receiver's divisor are checked against each other.

// File: rtl/abd_pkg.sv
package abd_pkg;

  localparam logic [7:0] SyncByte = 8'h55;
  localparam int FrameBits = 10;

  typedef enum logic [2:0] {
    RxIdle, RxBreak, RxDelim, RxSync, RxWaitHigh
  } rxState_e;

  typedef enum logic [1:0] {
    TxIdle, TxBreak, TxDelim, TxFrame
  } txState_e;

  // control -> datapath
  typedef struct packed {
    logic lenClr;
    logic lenInc;
    logic measClr;
    logic measInc;
    logic divLoad;
    logic flagClr;
    logic brkToSet;
    logic syncToSet;
    logic txRestart;
    logic txRun;
    logic txShiftLoad;
    logic txShiftStep;
    logic txDriveLow;
    logic txDriveFrame;
  } abdStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic       rxFall;
    logic       brkLong;
    logic       brkOver;
    logic       delimOk;
    logic       measFull;
    logic       txBitEnd;
    logic [3:0] txSeg;
  } abdStatus_t;

endpackage

// File: rtl/abd_datapath.sv
module abd_datapath
  import abd_pkg::*;
#(
  parameter int CntW       = 16,
  parameter int BrkMinBits = 11,
  parameter int BrkMaxBits = 22,
  parameter int MeasBits   = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            rxIn,
  input  logic [CntW-1:0] bitTime,
  input  logic [1:0]      delimSel,
  input  abdStrobe_t      strobe,
  output abdStatus_t      status,
  output logic [CntW-1:0] divisor,
  output logic            detectDone,
  output logic            breakTimeout,
  output logic            syncTimeout,
  output logic            txOut
);

  localparam int LenW     = CntW + 5;
  localparam int DivShift = $clog2(MeasBits);

  logic                 rxPrev;
  logic [LenW-1:0]      lenCnt;
  logic [CntW-1:0]      measCnt;
  logic [CntW-1:0]      divQ;
  logic                 doneQ;
  logic                 brkToQ;
  logic                 syncToQ;
  logic [CntW-1:0]      txCyc;
  logic [3:0]           txSegQ;
  logic [FrameBits-1:0] txShift;

  logic [LenW-1:0] unitLen;
  logic [LenW-1:0] brkMinLen;
  logic [LenW-1:0] brkMaxLen;
  logic [LenW-1:0] delimLen;

  always_comb begin
    unitLen   = LenW'(bitTime);
    brkMinLen = unitLen * LenW'(BrkMinBits);
    brkMaxLen = unitLen * LenW'(BrkMaxBits);
    delimLen  = unitLen * (LenW'(delimSel) + LenW'(1));
  end

  always_comb begin
    status.rxFall   = rxPrev & ~rxIn;
    status.brkLong  = lenCnt >= brkMinLen;
    status.brkOver  = lenCnt >= brkMaxLen;
    status.delimOk  = lenCnt >= delimLen;
    status.measFull = &measCnt;
    status.txBitEnd = ({1'b0, txCyc} + (CntW+1)'(1)) >= {1'b0, bitTime};
    status.txSeg    = txSegQ;
  end

  // receive side: edge history, length counter, measurement counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPrev  <= 1'b1;
      lenCnt  <= '0;
      measCnt <= '0;
    end else begin
      rxPrev <= rxIn;
      if (strobe.lenClr)
        lenCnt <= LenW'(1);
      else if (strobe.lenInc && !(&lenCnt))
        lenCnt <= lenCnt + LenW'(1);
      if (strobe.measClr)
        measCnt <= CntW'(1);
      else if (strobe.measInc)
        measCnt <= measCnt + CntW'(1);
    end
  end

  // result and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ    <= '0;
      doneQ   <= 1'b0;
      brkToQ  <= 1'b0;
      syncToQ <= 1'b0;
    end else begin
      doneQ <= strobe.divLoad;
      if (strobe.divLoad)
        divQ <= measCnt >> DivShift;
      if (strobe.flagClr) begin
        brkToQ  <= 1'b0;
        syncToQ <= 1'b0;
      end else begin
        if (strobe.brkToSet)  brkToQ  <= 1'b1;
        if (strobe.syncToSet) syncToQ <= 1'b1;
      end
    end
  end

  // transmit side: bit timer, segment counter, frame shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCyc   <= '0;
      txSegQ  <= '0;
      txShift <= '1;
    end else begin
      if (strobe.txRestart) begin
        txCyc  <= '0;
        txSegQ <= '0;
      end else if (strobe.txRun) begin
        if (status.txBitEnd) begin
          txCyc  <= '0;
          txSegQ <= txSegQ + 4'd1;
        end else begin
          txCyc <= txCyc + CntW'(1);
        end
      end
      if (strobe.txShiftLoad)
        txShift <= {1'b1, SyncByte, 1'b0};
      else if (strobe.txShiftStep)
        txShift <= {1'b1, txShift[FrameBits-1:1]};
    end
  end

  always_comb begin
    if (strobe.txDriveLow)
      txOut = 1'b0;
    else if (strobe.txDriveFrame)
      txOut = txShift[0];
    else
      txOut = 1'b1;
  end

  assign divisor      = divQ;
  assign detectDone   = doneQ;
  assign breakTimeout = brkToQ;
  assign syncTimeout  = syncToQ;

endmodule

// File: rtl/abd_control.sv
module abd_control
  import abd_pkg::*;
#(
  parameter int TxBrkBits = 13,
  parameter int SyncFalls = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       rxIn,
  input  logic [1:0] delimSel,
  input  logic       txBreakReq,
  input  logic       txWrite,
  input  logic [7:0] txByte,
  input  abdStatus_t status,
  output abdStrobe_t strobe,
  output logic       txBusy
);

  localparam int FallW = $clog2(SyncFalls);
  localparam logic [FallW-1:0] LastFall = FallW'(SyncFalls - 2);
  localparam logic [3:0] BrkLastSeg   = 4'(TxBrkBits - 1);
  localparam logic [3:0] FrameLastSeg = 4'(FrameBits - 1);

  rxState_e         rxState, rxNext;
  txState_e         txState, txNext;
  logic [FallW-1:0] fallNum, fallNext;
  logic             syncMode, syncModeNext;
  logic             txAccept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState  <= RxIdle;
      txState  <= TxIdle;
      fallNum  <= '0;
      syncMode <= 1'b0;
    end else begin
      rxState  <= rxNext;
      txState  <= txNext;
      fallNum  <= fallNext;
      syncMode <= syncModeNext;
    end
  end

  assign txAccept = txWrite && txBreakReq &&
                    ((enable && txByte == SyncByte) || (!enable && txByte == 8'h00));

  always_comb begin
    strobe       = '0;
    rxNext       = rxState;
    fallNext     = fallNum;
    txNext       = txState;
    syncModeNext = syncMode;

    // receive sequence
    if (!enable) begin
      rxNext         = RxIdle;
      strobe.flagClr = 1'b1;
    end else begin
      unique case (rxState)
        RxIdle: begin
          if (!rxIn) begin
            strobe.lenClr  = 1'b1;
            strobe.flagClr = 1'b1;
            rxNext         = RxBreak;
          end
        end
        RxBreak: begin
          if (!rxIn) begin
            if (status.brkOver) begin
              strobe.brkToSet = 1'b1;
              rxNext          = RxWaitHigh;
            end else begin
              strobe.lenInc = 1'b1;
            end
          end else if (status.brkLong) begin
            strobe.lenClr = 1'b1;
            rxNext        = RxDelim;
          end else begin
            rxNext = RxIdle;
          end
        end
        RxDelim: begin
          if (rxIn) begin
            strobe.lenInc = 1'b1;
          end else if (status.delimOk) begin
            strobe.measClr = 1'b1;
            fallNext       = '0;
            rxNext         = RxSync;
          end else begin
            strobe.lenClr = 1'b1;
            rxNext        = RxBreak;
          end
        end
        RxSync: begin
          if (status.rxFall && fallNum == LastFall) begin
            strobe.divLoad = 1'b1;
            rxNext         = RxWaitHigh;
          end else if (status.measFull) begin
            strobe.syncToSet = 1'b1;
            rxNext           = RxWaitHigh;
          end else begin
            strobe.measInc = 1'b1;
            if (status.rxFall) fallNext = fallNum + FallW'(1);
          end
        end
        RxWaitHigh: begin
          if (rxIn) rxNext = RxIdle;
        end
        default: rxNext = RxIdle;
      endcase
    end

    // transmit sequence
    unique case (txState)
      TxIdle: begin
        if (txAccept) begin
          strobe.txRestart = 1'b1;
          syncModeNext     = enable;
          txNext           = TxBreak;
        end
      end
      TxBreak: begin
        strobe.txDriveLow = 1'b1;
        if (status.txBitEnd && status.txSeg == BrkLastSeg) begin
          strobe.txRestart = 1'b1;
          txNext           = syncMode ? TxDelim : TxIdle;
        end else begin
          strobe.txRun = 1'b1;
        end
      end
      TxDelim: begin
        if (status.txBitEnd && status.txSeg == {2'b00, delimSel}) begin
          strobe.txRestart   = 1'b1;
          strobe.txShiftLoad = 1'b1;
          txNext             = TxFrame;
        end else begin
          strobe.txRun = 1'b1;
        end
      end
      TxFrame: begin
        strobe.txDriveFrame = 1'b1;
        if (status.txBitEnd) strobe.txShiftStep = 1'b1;
        if (status.txBitEnd && status.txSeg == FrameLastSeg)
          txNext = TxIdle;
        else
          strobe.txRun = 1'b1;
      end
      default: txNext = TxIdle;
    endcase
  end

  assign txBusy = (txState != TxIdle);

endmodule

// File: rtl/brk_sync_autobaud.sv
module brk_sync_autobaud
  import abd_pkg::*;
#(
  parameter int CntW       = 16,
  parameter int BrkMinBits = 11,
  parameter int BrkMaxBits = 22,
  parameter int TxBrkBits  = 13
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            rxIn,
  input  logic [CntW-1:0] bitTime,
  input  logic [1:0]      delimSel,
  input  logic            txBreakReq,
  input  logic            txWrite,
  input  logic [7:0]      txByte,
  output logic [CntW-1:0] divisor,
  output logic            detectDone,
  output logic            breakTimeout,
  output logic            syncTimeout,
  output logic            txOut,
  output logic            txBusy
);

  abdStrobe_t strobe;
  abdStatus_t status;

  abd_control #(
    .TxBrkBits(TxBrkBits),
    .SyncFalls(5)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .rxIn      (rxIn),
    .delimSel  (delimSel),
    .txBreakReq(txBreakReq),
    .txWrite   (txWrite),
    .txByte    (txByte),
    .status    (status),
    .strobe    (strobe),
    .txBusy    (txBusy)
  );

  abd_datapath #(
    .CntW      (CntW),
    .BrkMinBits(BrkMinBits),
    .BrkMaxBits(BrkMaxBits),
    .MeasBits  (8)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .rxIn        (rxIn),
    .bitTime     (bitTime),
    .delimSel    (delimSel),
    .strobe      (strobe),
    .status      (status),
    .divisor     (divisor),
    .detectDone  (detectDone),
    .breakTimeout(breakTimeout),
    .syncTimeout (syncTimeout),
    .txOut       (txOut)
  );

endmodule

// File: rtl/abd_checker.sv
module abd_checker #(
  parameter int CntW = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            enable,
  input logic            rxIn,
  input logic            txBreakReq,
  input logic            txWrite,
  input logic [CntW-1:0] divisor,
  input logic            detectDone,
  input logic            breakTimeout,
  input logic            syncTimeout,
  input logic            txOut,
  input logic            txBusy
);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    detectDone |=> !detectDone);

  assert_div_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !detectDone |-> $stable(divisor));

  assert_overflow_keeps_div_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncTimeout) |-> $stable(divisor) && !detectDone);

  assert_brk_timeout_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakTimeout) |-> !$past(rxIn));

  assert_disabled_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !breakTimeout && !syncTimeout && !detectDone);

  assert_tx_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> $past(txWrite && txBreakReq));

  assert_tx_idle_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txOut);

endmodule

bind brk_sync_autobaud abd_checker #(.CntW(CntW)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .rxIn        (rxIn),
  .txBreakReq  (txBreakReq),
  .txWrite     (txWrite),
  .divisor     (divisor),
  .detectDone  (detectDone),
  .breakTimeout(breakTimeout),
  .syncTimeout (syncTimeout),
  .txOut       (txOut),
  .txBusy      (txBusy)
);

// File: tb/tb_brk_sync_autobaud.sv
module tb_brk_sync_autobaud;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        rxDrive = 1'b1;
  logic        loopBack = 1'b0;
  logic [15:0] bitTime = 16'd10;
  logic [1:0]  delimSel = 2'd0;
  logic        txBreakReq = 1'b0;
  logic        txWrite = 1'b0;
  logic [7:0]  txByte = 8'h00;
  logic [15:0] divisor;
  logic        detectDone, breakTimeout, syncTimeout, txOut, txBusy;
  logic        rxIn;

  int nChecks = 0;
  int nFails = 0;
  int expQ[$];

  assign rxIn = loopBack ? txOut : rxDrive;

  always #10 clk = ~clk;

  brk_sync_autobaud dut (
    .clk(clk), .rstN(rstN), .enable(enable), .rxIn(rxIn), .bitTime(bitTime),
    .delimSel(delimSel), .txBreakReq(txBreakReq), .txWrite(txWrite), .txByte(txByte),
    .divisor(divisor), .detectDone(detectDone), .breakTimeout(breakTimeout),
    .syncTimeout(syncTimeout), .txOut(txOut), .txBusy(txBusy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: every done pulse pops one expected divisor
  always @(negedge clk) begin
    if (rstN && detectDone) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R4 unexpected detection", int'(divisor), -1);
      end else begin
        int e;
        e = expQ.pop_front();
        check(int'(divisor) == e, "R4 divisor", int'(divisor), e);
      end
    end
  end

  task automatic drained(input string req);
    check(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  task automatic rxHold(input bit v, input int n);
    rxDrive = v;
    repeat (n) @(negedge clk);
  endtask

  function automatic bit syncSeg(input int i);
    if (i == 0) return 1'b0;
    if (i <= 8) return 1'(8'h55 >> (i - 1));
    return 1'b1;
  endfunction

  task automatic sendSync(input int bs, input int nSeg);
    for (int i = 0; i < nSeg; i++) rxHold(syncSeg(i), bs);
  endtask

  task automatic preamble(input int brkLen, input int delimLen, input int bs);
    rxHold(1'b0, brkLen);
    rxHold(1'b1, delimLen);
    sendSync(bs, 10);
    rxHold(1'b1, 30);
  endtask

  function automatic bit txExpBit(input int k, input bit full, input int d);
    if (k < 13) return 1'b0;
    if (!full) return 1'b1;
    if (k < 14 + d) return 1'b1;
    return syncSeg(k - 14 - d);
  endfunction

  task automatic txSend(input logic [7:0] b, input bit full, input bit retrig, input string req);
    int nBits, total, bt, d;
    bt = int'(bitTime);
    d = int'(delimSel);
    nBits = full ? (13 + d + 1 + 10) : 13;
    total = nBits * bt;
    txBreakReq = 1'b1;
    txByte = b;
    txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
    for (int j = 0; j <= total; j++) begin
      if (j < total && (j % bt) == bt / 2)
        check(txOut == txExpBit(j / bt, full, d), req, int'(txOut), int'(txExpBit(j / bt, full, d)));
      if (j == total - 1) check(txBusy == 1'b1, req, int'(txBusy), 1);
      if (j == total) begin
        check(txBusy == 1'b0, req, int'(txBusy), 0);
        check(txOut == 1'b1, req, int'(txOut), 1);
      end
      txWrite = (retrig && j == 3) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    txWrite = 1'b0;
  endtask

  task automatic txIgnored(input logic [7:0] b, input bit req, input string tag);
    txBreakReq = req;
    txByte = b;
    txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
    repeat (3) begin
      check(txBusy == 1'b0 && txOut == 1'b1, tag, int'(txBusy), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(divisor == 16'd0, "R1 divisor", int'(divisor), 0);
    check(!detectDone && !breakTimeout && !syncTimeout, "R1 flags",
          int'({detectDone, breakTimeout, syncTimeout}), 0);
    check(txOut == 1'b1 && txBusy == 1'b0, "R1 tx idle", int'({txOut, txBusy}), 2);

    enable = 1'b1;
    bitTime = 16'd10;
    delimSel = 2'd0;
    @(negedge clk);

    // R4 basic measurement
    expQ.push_back(20);
    preamble(120, 10, 20);
    drained("R4 basic detection");

    // R2 and R3 exact minimum break and delimiter
    delimSel = 2'd3;
    expQ.push_back(37);
    preamble(110, 40, 37);
    drained("R2 R3 minimum break and delimiter");

    // R3 delimiter one clock short
    preamble(120, 39, 25);
    drained("R3 short delimiter");
    check(divisor == 16'd37, "R3 divisor kept", int'(divisor), 37);

    // R2 break one clock short
    preamble(109, 40, 20);
    drained("R2 short break");
    check(divisor == 16'd37, "R2 divisor kept", int'(divisor), 37);

    // R5 exactly 22 bit times is valid
    expQ.push_back(15);
    preamble(220, 40, 15);
    drained("R5 limit break");
    check(breakTimeout == 1'b0, "R5 no flag at limit", int'(breakTimeout), 0);

    // R5 one clock over the limit
    rxHold(1'b0, 221);
    rxHold(1'b1, 5);
    check(breakTimeout == 1'b1, "R5 break timeout", int'(breakTimeout), 1);
    rxHold(1'b1, 40);
    drained("R5 no detection after timeout");
    expQ.push_back(12);
    preamble(120, 40, 12);
    drained("R5 recovery");
    check(breakTimeout == 1'b0, "R5 flag cleared by new break", int'(breakTimeout), 0);

    // R6 measurement overflow
    delimSel = 2'd0;
    rxHold(1'b0, 120);
    rxHold(1'b1, 10);
    sendSync(8200, 8);
    rxHold(1'b1, 20);
    check(syncTimeout == 1'b1, "R6 sync timeout", int'(syncTimeout), 1);
    check(divisor == 16'd12, "R6 divisor unchanged", int'(divisor), 12);
    drained("R6 no detection");

    // R7 disable clears flags and blocks detection
    rxHold(1'b0, 250);
    rxHold(1'b1, 5);
    check(breakTimeout == 1'b1, "R7 flag set before disable", int'(breakTimeout), 1);
    enable = 1'b0;
    rxHold(1'b1, 2);
    check(!breakTimeout && !syncTimeout, "R7 flags cleared",
          int'({breakTimeout, syncTimeout}), 0);
    preamble(120, 10, 20);
    drained("R7 no detection while disabled");
    check(divisor == 16'd12, "R7 divisor unchanged", int'(divisor), 12);

    // R8 full preamble looped back into the receiver
    enable = 1'b1;
    bitTime = 16'd6;
    delimSel = 2'd1;
    txBreakReq = 1'b1;
    rxHold(1'b1, 3);
    loopBack = 1'b1;
    expQ.push_back(6);
    txSend(8'h55, 1'b1, 1'b0, "R8 tx waveform");
    repeat (5) @(negedge clk);
    drained("R8 loopback detection");
    check(divisor == 16'd6, "R8 divisor from loopback", int'(divisor), 6);
    loopBack = 1'b0;

    // R9 plain break while disabled, with a retrigger attempt (R10)
    enable = 1'b0;
    bitTime = 16'd5;
    txSend(8'h00, 1'b0, 1'b1, "R9 R10 plain break");

    // R10 ignored writes
    txIgnored(8'h55, 1'b1, "R10 wrong byte disabled");
    enable = 1'b1;
    txIgnored(8'h00, 1'b1, "R10 wrong byte enabled");
    txIgnored(8'h55, 1'b0, "R10 no break request");

    repeat (5) @(negedge clk);
    drained("R4 final queue");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule